// File: doc/BRIEF.md
# Code-Region Qualified Shadow RAM Selector

This block routes memory accesses of an 8-bit processor system that has a fast RAM bank placed over a slower video RAM. The access address alone does not choose the memory. The address of the instruction in progress also takes part. On every opcode fetch the block records whether that opcode came from the privileged operating-system code range. It keeps that record for the rest of the instruction.

With shadow mode off, the whole RAM space belongs to video RAM. With shadow mode on, the fast bank becomes the main memory for code and data. The one exception is the screen region. There, an access from privileged code reaches video RAM, and an access from any other code lands in the fast bank that overlays it. The block has two outputs, one chip select per memory. Both are combinational functions of the current cycle's inputs and the registered origin flag.

Every region bound is a parameter. There is no data path through the block, so the pins are plain control signals with no valid/ready handshake and no back-pressure.

Top module: `shadow_ram_selector`

## Requirements
- R1: An opcode fetch is a cycle with `op_fetch`=1 and `rd_nwr`=1 (1 = read). At the clock edge ending that cycle, the origin flag takes 1 if `addr` lies in [PRIV_BASE, PRIV_TOP], and 0 otherwise.
- R2: In every cycle that is not an opcode fetch, the origin flag keeps its value. This includes a cycle with `op_fetch`=1 and `rd_nwr`=0, where the strobe is ignored.
- R3: During an opcode-fetch cycle, routing uses the privilege of that cycle's own fetch address, not the stored flag.
- R4: With `shadow_en`=1, an address in [0, RAM_TOP] outside [SCRN_BASE, SCRN_TOP] asserts `fast_cs` only.
- R5: With `shadow_en`=1, an address in [SCRN_BASE, SCRN_TOP] under privileged origin asserts `video_cs` only.
- R6: With `shadow_en`=1, an address in [SCRN_BASE, SCRN_TOP] under unprivileged origin asserts `fast_cs` only.
- R7: With `shadow_en`=0, every address in [0, RAM_TOP] asserts `video_cs` only, whatever the flag holds.
- R8: An address above RAM_TOP asserts neither chip select.
- R9: `fast_cs` and `video_cs` are never high in the same cycle.
- R10: A clock edge with `rst_n`=0 clears the origin flag, so execution begins unprivileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_fetch | input | 1 | High while the processor fetches an opcode byte |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| addr | input | ADDR_W | Address bus |
| shadow_en | input | 1 | Enables the fast RAM overlay |
| fast_cs | output | 1 | Chip select of the fast RAM bank |
| video_cs | output | 1 | Chip select of the video RAM |

## Verification
The bench builds the block with an 8-bit address bus. RAM occupies 0x00–0x7F, the screen region is 0x30–0x7F, and privileged code sits at 0xC0–0xFF. At this size, each combination of shadow mode and origin state gets a sweep over all 256 addresses. These sweeps reach every region edge, the boundary above RAM, and both ends of the privileged range as fetch addresses. Fetches with the write strobe, fetches inside the screen region, and a reset in the middle of the run are also exercised. Expected selects come from interval arithmetic on the parameters.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_FAST  = 2'd1,
    ROUTE_VIDEO = 2'd2
  } route_t;

  localparam int NUM_WIN  = 3;
  localparam int WIN_RAM  = 0;
  localparam int WIN_SCRN = 1;
  localparam int WIN_PRIV = 2;
endpackage

// File: rtl/addr_window.sv
`timescale 1ns/1ps
module addr_window #(
  parameter int          ADDR_W = 16,
  parameter int unsigned LO     = 0,
  parameter int unsigned HI     = 32'hFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam longint unsigned FULL = (64'd1 << ADDR_W) - 64'd1;

  logic lo_ok;
  logic hi_ok;

  generate
    if (LO == 0) begin : g_lo_open
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = (addr >= ADDR_W'(LO));
    end
    if (longint'(HI) >= longint'(FULL)) begin : g_hi_open
      assign hi_ok = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok = (addr <= ADDR_W'(HI));
    end
  endgenerate

  assign hit = lo_ok & hi_ok;
endmodule

// File: rtl/fetch_origin_flag.sv
`timescale 1ns/1ps
module fetch_origin_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic priv_hit,
  output logic origin_q,
  output logic priv_now
);
  always_ff @(posedge clk) begin
    if (!rst_n)    origin_q <= 1'b0;
    else if (load) origin_q <= priv_hit;
  end

  // during the fetch cycle the instruction in progress is the one being fetched
  assign priv_now = load ? priv_hit : origin_q;
endmodule

// File: rtl/route_matrix.sv
`timescale 1ns/1ps
module route_matrix
  import shadow_pkg::*;
(
  input  logic   in_ram,
  input  logic   in_screen,
  input  logic   shadow_en,
  input  logic   priv_now,
  output route_t route
);
  always_comb begin
    route = ROUTE_NONE;
    if (in_ram) begin
      if (!shadow_en)              route = ROUTE_VIDEO;
      else if (in_screen && priv_now) route = ROUTE_VIDEO;
      else                         route = ROUTE_FAST;
    end
  end
endmodule

// File: rtl/shadow_ram_selector.sv
`timescale 1ns/1ps
module shadow_ram_selector
  import shadow_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int unsigned RAM_TOP   = 32'h7FFF,
  parameter int unsigned SCRN_BASE = 32'h3000,
  parameter int unsigned SCRN_TOP  = 32'h7FFF,
  parameter int unsigned PRIV_BASE = 32'hC000,
  parameter int unsigned PRIV_TOP  = 32'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_fetch,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              shadow_en,
  output logic              fast_cs,
  output logic              video_cs
);
  localparam int unsigned WIN_LO [NUM_WIN] = '{0, SCRN_BASE, PRIV_BASE};
  localparam int unsigned WIN_HI [NUM_WIN] = '{RAM_TOP, SCRN_TOP, PRIV_TOP};

  logic [NUM_WIN-1:0] win_hit;
  logic               fetch_cyc;
  logic               origin_q;
  logic               priv_now;
  route_t             route;

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      addr_window #(
        .ADDR_W(ADDR_W),
        .LO    (WIN_LO[g]),
        .HI    (WIN_HI[g])
      ) u_win (
        .addr(addr),
        .hit (win_hit[g])
      );
    end
  endgenerate

  assign fetch_cyc = op_fetch & rd_nwr;

  fetch_origin_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fetch_cyc),
    .priv_hit(win_hit[WIN_PRIV]),
    .origin_q(origin_q),
    .priv_now(priv_now)
  );

  route_matrix u_route (
    .in_ram   (win_hit[WIN_RAM]),
    .in_screen(win_hit[WIN_SCRN]),
    .shadow_en(shadow_en),
    .priv_now (priv_now),
    .route    (route)
  );

  assign fast_cs  = (route == ROUTE_FAST);
  assign video_cs = (route == ROUTE_VIDEO);
endmodule

// File: rtl/shadow_sel_chk.sv
`timescale 1ns/1ps
module shadow_sel_chk #(
  parameter int          ADDR_W    = 16,
  parameter int unsigned RAM_TOP   = 32'h7FFF,
  parameter int unsigned SCRN_BASE = 32'h3000,
  parameter int unsigned SCRN_TOP  = 32'h7FFF,
  parameter int unsigned PRIV_BASE = 32'hC000,
  parameter int unsigned PRIV_TOP  = 32'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_fetch,
  input logic              rd_nwr,
  input logic [ADDR_W-1:0] addr,
  input logic              shadow_en,
  input logic              fast_cs,
  input logic              video_cs,
  input logic              origin_q
);
  logic in_ram, in_scr, in_priv, is_fetch;
  assign in_ram   = longint'(addr) <= longint'(RAM_TOP);
  assign in_scr   = longint'(addr) >= longint'(SCRN_BASE) && longint'(addr) <= longint'(SCRN_TOP);
  assign in_priv  = longint'(addr) >= longint'(PRIV_BASE) && longint'(addr) <= longint'(PRIV_TOP);
  assign is_fetch = op_fetch && rd_nwr;

  // R1
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> origin_q == $past(in_priv));
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fetch |=> $stable(origin_q));
  // R5
  priv_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && in_ram && in_scr && !is_fetch && origin_q) |-> video_cs);
  // R7
  shadow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && in_ram) |-> (video_cs && !fast_cs));
  // R8
  above_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ram |-> (!fast_cs && !video_cs));
  // R9
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_cs && video_cs));
  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !origin_q);
endmodule

bind shadow_ram_selector shadow_sel_chk #(
  .ADDR_W   (ADDR_W),
  .RAM_TOP  (RAM_TOP),
  .SCRN_BASE(SCRN_BASE),
  .SCRN_TOP (SCRN_TOP),
  .PRIV_BASE(PRIV_BASE),
  .PRIV_TOP (PRIV_TOP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_fetch (op_fetch),
  .rd_nwr   (rd_nwr),
  .addr     (addr),
  .shadow_en(shadow_en),
  .fast_cs  (fast_cs),
  .video_cs (video_cs),
  .origin_q (origin_q)
);

// File: tb/sim_shadow_ram_selector.sv
`timescale 1ns/1ps
module sim_shadow_ram_selector;
  localparam int AW = 8;
  localparam int RT = 8'h7F, SB = 8'h30, ST = 8'h7F, PB = 8'hC0, PT = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_fetch = 1'b0;
  logic rd_nwr = 1'b1;
  logic [AW-1:0] addr = '0;
  logic shadow_en = 1'b0;
  logic fast_cs, video_cs;

  int checks = 0;
  int failures = 0;
  bit model_priv = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shadow_ram_selector #(
    .ADDR_W(AW), .RAM_TOP(RT), .SCRN_BASE(SB), .SCRN_TOP(ST),
    .PRIV_BASE(PB), .PRIV_TOP(PT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .op_fetch(op_fetch), .rd_nwr(rd_nwr),
    .addr(addr), .shadow_en(shadow_en), .fast_cs(fast_cs), .video_cs(video_cs)
  );

  function automatic bit is_priv(int a);
    return a >= PB && a <= PT;
  endfunction

  task automatic check(string tag, bit ef, bit ev);
    checks++;
    if (fast_cs !== ef || video_cs !== ev) begin
      failures++;
      $display("FAIL %s addr=%02h shadow=%0b fast/video actual=%0b%0b expected=%0b%0b",
               tag, addr, shadow_en, fast_cs, video_cs, ef, ev);
    end
  endtask

  task automatic expect_route(string tag, int a, bit sh, bit pr);
    bit ram, scr;
    ram = a <= RT;
    scr = a >= SB && a <= ST;
    check(tag, ram && sh && (!scr || !pr), ram && (!sh || (scr && pr)));
  endtask

  // all addresses in data cycles, origin held by the model
  task automatic sweep(bit sh);
    for (int a = 0; a < 256; a++) begin
      string t;
      @(negedge clk);
      op_fetch = 1'b0; rd_nwr = a[0]; addr = AW'(a); shadow_en = sh;
      #1;
      if (a > RT) t = "R8";
      else if (!sh) t = "R7";
      else if (a >= SB) t = model_priv ? "R5/R2" : "R6/R2";
      else t = "R4";
      expect_route(t, a, sh, model_priv);
    end
  endtask

  task automatic fetch(int a, bit rd, bit sh);
    @(negedge clk);
    op_fetch = 1'b1; rd_nwr = rd; addr = AW'(a); shadow_en = sh;
    #1;
    if (rd) expect_route("R3", a, sh, is_priv(a));
    else    expect_route("R2 write-strobe", a, sh, model_priv);
    @(posedge clk);
    if (rd) model_priv = is_priv(a);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    shadow_en = 1'b1; addr = 8'h40; #1;
    check("R10 in reset", 1'b1, 1'b0);
    rst_n = 1'b1;
    // R10: starts unprivileged
    sweep(1'b1);
    // R1: fetch at bottom edge of privileged range
    fetch(PB, 1'b1, 1'b1);
    sweep(1'b1);
    sweep(1'b0); // R7 with flag set
    // R1: fetch just below privileged range
    fetch(PB - 1, 1'b1, 1'b1);
    sweep(1'b1);
    sweep(1'b0);
    // R1/R3: top of privileged range
    fetch(PT, 1'b1, 1'b1);
    sweep(1'b1);
    // R2: strobe with write is ignored
    fetch(8'h10, 1'b0, 1'b1);
    sweep(1'b1);
    // R3: fetch from the screen region while flag is set
    fetch(8'h40, 1'b1, 1'b1);
    sweep(1'b1);
    // R3: fetch from screen region with shadow off
    fetch(8'h50, 1'b1, 1'b0);
    fetch(8'hE0, 1'b1, 1'b1);
    // R10: reset in the middle clears the flag
    @(negedge clk);
    rst_n = 1'b0; op_fetch = 1'b0;
    @(posedge clk);
    model_priv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sweep(1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule